// File: doc/BRIEF.md
# Flat-Counter Display Timing Engine

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel video interface. It also produces the colour word for each pixel clock. A single counter runs through the whole frame in pixel clocks. A second counter wraps every line. The origin of every line is the leading edge of the horizontal sync pulse. All vertical events (the vsync pulse and the vertical display window) are absolute pixel positions inside the frame, not line numbers. Software therefore programs values such as `lines * htotal` directly.

Configuration arrives through a one-cycle register write port. Every setting is written into a shadow set. The shadow set is copied into the working set only at a frame start, so a write in mid-frame never tears a frame. Clearing the enable bit lets the current frame run to its end before the engine stops. Setting enable again before that point continues without a gap.

Inside the display window the block accepts pixels through a valid/ready handshake, with ready equal to data-enable. When valid is low inside the window, the block outputs a programmable underflow colour and sets a sticky flag. Outside the window it outputs a border colour. The output colour is then truncated to 4, 5, 6 or 8 bits per component.

Top module: `disp_tgen`

## Requirements
- R1: After reset the engine is idle and all of these are low: `hsync_o`, `vsync_o`, `de_o`, `pix_rdy_o`, `frame_o` and `uflow_o`. The engine stays idle until bit 0 of register 0 (enable) is written as 1.
- R2: Let position p be the frame counter value and h = p mod htotal. Register 1 holds htotal in bits [11:0] and the pulse width in bits [27:16]. Unshifted hsync is active for h < pulse width.
- R3: Unshifted vsync is active for skew <= p < skew + vlen. vlen is in register 4, bits [23:0]. skew is in register 7, bits [23:0].
- R4: `de_o` is high only when both windows hold. The horizontal window is hbeg <= h <= hend, with register 2 holding hbeg in bits [11:0] and hend in bits [27:16]. The vertical window is vbeg <= p <= vend, with vbeg in register 5 and vend in register 6. `pix_rdy_o` equals `de_o`. The frame counter wraps after fper - 1, with fper in register 3.
- R5: The colour output is chosen as follows. With `de_o` high and valid high, it is the input pixel. With `de_o` high and valid low, it is the underflow colour (register 10, reset value 0x0000FF). With `de_o` low, it is the border colour (register 9, reset value 0).
- R6: Register 8 bit 0 inverts hsync and bit 1 inverts vsync. Both reset to 0, which means active-high.
- R7: Clearing enable stops the engine only after the last position of the current frame. If enable is set again before that position, the next frame follows with no gap. While idle, `de_o` and `frame_o` stay low.
- R8: Every register write lands in the shadow set. The shadow set reaches the outputs only from the next frame start on.
- R9: Register 11 bits [1:0] select the component depth: 0 is 8 bits, 1 is 4 bits, 2 is 5 bits, 3 is 6 bits. Each 8-bit component of the output keeps only its top bits.
- R10: `frame_o` is high exactly at p = 0 while running. `uflow_o` is set when `de_o` is high and valid is low. It stays set until a write to register 12. A new underflow in the same cycle as the clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 32 | Register write data |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_data_i | input | 24 | Input pixel, three 8-bit components |
| pix_rdy_o | output | 1 | Pixel accepted this cycle (equals data-enable) |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data-enable, active high |
| pix_o | output | 24 | Output colour after depth truncation |
| frame_o | output | 1 | High at the first position of each frame |
| uflow_o | output | 1 | Sticky underflow flag |

## Verification
The syncs, data-enable, ready, frame strobe and colour are combinational functions of the registered counter state and the current pixel inputs. The bench drives each input at a falling edge and samples one time unit later, against the position reached at the preceding rising edge. A register write lands in the shadow set at the next rising edge and reaches the outputs at the first position of the following frame. Enable starts the frame counter one edge after the shadow update. The bench therefore locks onto the first `frame_o` and from then on counts positions itself. It applies each mid-frame write at a known position and changes its model parameters only at the frame boundary. The sticky flag is compared at the last position of each frame, once every gap of that frame has had its edge.

// File: rtl/tg_pkg.sv
package tg_pkg;
    localparam int TG_HW = 12;
    localparam int TG_FW = 24;
    localparam int TG_CW = 8;
    localparam int TG_NC = 3;
    localparam int TG_PW = TG_CW * TG_NC;
    localparam int TG_AW = 4;
    localparam int TG_DW = 32;

    typedef enum logic [TG_AW-1:0] {
        RA_CTRL  = 4'd0,
        RA_HTIME = 4'd1,
        RA_HWIN  = 4'd2,
        RA_FPER  = 4'd3,
        RA_VLEN  = 4'd4,
        RA_VBEG  = 4'd5,
        RA_VEND  = 4'd6,
        RA_SKEW  = 4'd7,
        RA_POL   = 4'd8,
        RA_BORD  = 4'd9,
        RA_UFL   = 4'd10,
        RA_FMT   = 4'd11,
        RA_CLR   = 4'd12
    } tg_reg_e;

    typedef struct packed {
        logic [TG_HW-1:0] htot;
        logic [TG_HW-1:0] hpw;
        logic [TG_HW-1:0] hbeg;
        logic [TG_HW-1:0] hend;
        logic [TG_FW-1:0] fper;
        logic [TG_FW-1:0] vlen;
        logic [TG_FW-1:0] vbeg;
        logic [TG_FW-1:0] vend;
        logic [TG_FW-1:0] skew;
        logic             hs_low;
        logic             vs_low;
        logic [TG_PW-1:0] border;
        logic [TG_PW-1:0] ufl;
        logic [1:0]       fmt;
    } tg_cfg_t;

    localparam tg_cfg_t TG_CFG_RST = '{ufl: TG_PW'(8'hFF), default: '0};
endpackage

// File: rtl/tg_regs.sv
module tg_regs
    import tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TG_AW-1:0] wr_addr,
    input  logic [TG_DW-1:0] wr_data,
    output tg_cfg_t          shadow_o,
    output logic             en_o,
    output logic             clr_o
);
    typedef struct packed {
        tg_cfg_t cfg;
        logic    en;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (tg_reg_e'(wr_addr))
                RA_CTRL:  d.en = wr_data[0];
                RA_HTIME: begin
                    d.cfg.htot = wr_data[TG_HW-1:0];
                    d.cfg.hpw  = wr_data[16 +: TG_HW];
                end
                RA_HWIN: begin
                    d.cfg.hbeg = wr_data[TG_HW-1:0];
                    d.cfg.hend = wr_data[16 +: TG_HW];
                end
                RA_FPER:  d.cfg.fper   = wr_data[TG_FW-1:0];
                RA_VLEN:  d.cfg.vlen   = wr_data[TG_FW-1:0];
                RA_VBEG:  d.cfg.vbeg   = wr_data[TG_FW-1:0];
                RA_VEND:  d.cfg.vend   = wr_data[TG_FW-1:0];
                RA_SKEW:  d.cfg.skew   = wr_data[TG_FW-1:0];
                RA_POL: begin
                    d.cfg.hs_low = wr_data[0];
                    d.cfg.vs_low = wr_data[1];
                end
                RA_BORD:  d.cfg.border = wr_data[TG_PW-1:0];
                RA_UFL:   d.cfg.ufl    = wr_data[TG_PW-1:0];
                RA_FMT:   d.cfg.fmt    = wr_data[1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg <= TG_CFG_RST;
            q.en  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign shadow_o = q.cfg;
    assign en_o     = q.en;
    assign clr_o    = wr_en && (tg_reg_e'(wr_addr) == RA_CLR);
endmodule

// File: rtl/tg_scan.sv
module tg_scan
    import tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  tg_cfg_t          shadow_i,
    output tg_cfg_t          act_o,
    output logic             run_o,
    output logic [TG_HW-1:0] hcnt_o,
    output logic [TG_FW-1:0] fcnt_o
);
    typedef struct packed {
        logic             run;
        logic [TG_HW-1:0] hcnt;
        logic [TG_FW-1:0] fcnt;
        tg_cfg_t          act;
    } scan_t;

    scan_t d, q;
    logic  last;
    logic [TG_HW:0] hnext;
    logic [TG_FW:0] fnext;

    always_comb begin
        hnext = {1'b0, q.hcnt} + (TG_HW+1)'(1);
        fnext = {1'b0, q.fcnt} + (TG_FW+1)'(1);
        last  = q.run && (fnext >= {1'b0, q.act.fper});
        d = q;
        if (!q.run) begin
            d.act = shadow_i;
            if (en_i) begin
                d.run  = 1'b1;
                d.hcnt = '0;
                d.fcnt = '0;
            end
        end else if (last) begin
            d.act  = shadow_i;
            d.run  = en_i;
            d.hcnt = '0;
            d.fcnt = '0;
        end else begin
            d.fcnt = fnext[TG_FW-1:0];
            d.hcnt = (hnext >= {1'b0, q.act.htot}) ? '0 : hnext[TG_HW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.run  <= 1'b0;
            q.hcnt <= '0;
            q.fcnt <= '0;
            q.act  <= TG_CFG_RST;
        end else begin
            q <= d;
        end
    end

    assign act_o  = q.act;
    assign run_o  = q.run;
    assign hcnt_o = q.hcnt;
    assign fcnt_o = q.fcnt;

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && last && en_i) |=> (q.run && q.fcnt == '0 && q.hcnt == '0));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !last) |=> q.run);
    assert_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !last) |=> $stable(q.act));
endmodule

// File: rtl/tg_pixel.sv
module tg_pixel
    import tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tg_cfg_t          act_i,
    input  logic             run_i,
    input  logic [TG_HW-1:0] hcnt_i,
    input  logic [TG_FW-1:0] fcnt_i,
    input  logic             clr_i,
    input  logic             pix_vld_i,
    input  logic [TG_PW-1:0] pix_data_i,
    output logic             pix_rdy_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [TG_PW-1:0] pix_o,
    output logic             frame_o,
    output logic             uflow_o
);
    logic uflow_d, uflow_q;
    logic hs_raw, vs_raw, hwin, vwin, de, miss;
    logic [TG_PW-1:0] col;
    logic [TG_CW-1:0] cmask;
    logic [TG_FW:0]   vs_end;

    always_comb begin
        vs_end = {1'b0, act_i.skew} + {1'b0, act_i.vlen};
        hs_raw = run_i && (hcnt_i < act_i.hpw);
        vs_raw = run_i && ({1'b0, fcnt_i} >= {1'b0, act_i.skew})
                       && ({1'b0, fcnt_i} < vs_end);
        hwin   = (hcnt_i >= act_i.hbeg) && (hcnt_i <= act_i.hend);
        vwin   = (fcnt_i >= act_i.vbeg) && (fcnt_i <= act_i.vend);
        de     = run_i && hwin && vwin;
        miss   = de && !pix_vld_i;
        col    = !de ? act_i.border : (pix_vld_i ? pix_data_i : act_i.ufl);
        case (act_i.fmt)
            2'd1:    cmask = {TG_CW{1'b1}} << (TG_CW - 4);
            2'd2:    cmask = {TG_CW{1'b1}} << (TG_CW - 5);
            2'd3:    cmask = {TG_CW{1'b1}} << (TG_CW - 6);
            default: cmask = {TG_CW{1'b1}};
        endcase
        uflow_d = miss ? 1'b1 : (clr_i ? 1'b0 : uflow_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uflow_q <= 1'b0;
        else        uflow_q <= uflow_d;
    end

    for (genvar g = 0; g < TG_NC; g++) begin : g_comp
        assign pix_o[g*TG_CW +: TG_CW] = col[g*TG_CW +: TG_CW] & cmask;
    end

    assign hsync_o   = hs_raw ^ act_i.hs_low;
    assign vsync_o   = vs_raw ^ act_i.vs_low;
    assign de_o      = de;
    assign pix_rdy_o = de;
    assign frame_o   = run_i && (fcnt_i == '0);
    assign uflow_o   = uflow_q;

    assert_uflow_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o && !pix_vld_i) |=> uflow_o);
    assert_uflow_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(de_o && !pix_vld_i)) |=> !uflow_o);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (!de_o && !frame_o && !pix_rdy_o));
endmodule

// File: rtl/disp_tgen.sv
module disp_tgen
    import tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TG_AW-1:0] wr_addr,
    input  logic [TG_DW-1:0] wr_data,
    input  logic             pix_vld_i,
    input  logic [TG_PW-1:0] pix_data_i,
    output logic             pix_rdy_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [TG_PW-1:0] pix_o,
    output logic             frame_o,
    output logic             uflow_o
);
    tg_cfg_t          shadow, act;
    logic             en, clr, run;
    logic [TG_HW-1:0] hcnt;
    logic [TG_FW-1:0] fcnt;

    tg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .shadow_o (shadow),
        .en_o     (en),
        .clr_o    (clr)
    );

    tg_scan u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .shadow_i (shadow),
        .act_o    (act),
        .run_o    (run),
        .hcnt_o   (hcnt),
        .fcnt_o   (fcnt)
    );

    tg_pixel u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (act),
        .run_i      (run),
        .hcnt_i     (hcnt),
        .fcnt_i     (fcnt),
        .clr_i      (clr),
        .pix_vld_i  (pix_vld_i),
        .pix_data_i (pix_data_i),
        .pix_rdy_o  (pix_rdy_o),
        .hsync_o    (hsync_o),
        .vsync_o    (vsync_o),
        .de_o       (de_o),
        .pix_o      (pix_o),
        .frame_o    (frame_o),
        .uflow_o    (uflow_o)
    );
endmodule

// File: tb/sim_disp_tgen.sv
module sim_disp_tgen;
    import tg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HT = 20, HD = 12, HSS = 14, HSE = 16;
    localparam int VT = 12, VD = 8, VSS = 9, VSE = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [TG_AW-1:0] wr_addr = '0;
    logic [TG_DW-1:0] wr_data = '0;
    logic pix_vld_i = 1'b0;
    logic [TG_PW-1:0] pix_data_i = '0;
    logic pix_rdy_o, hsync_o, vsync_o, de_o, frame_o, uflow_o;
    logic [TG_PW-1:0] pix_o;

    disp_tgen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_vld_i(pix_vld_i), .pix_data_i(pix_data_i),
        .pix_rdy_o(pix_rdy_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .pix_o(pix_o), .frame_o(frame_o), .uflow_o(uflow_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int m_ht, m_hpw, m_hb, m_he, m_fp, m_vl, m_vb, m_ve, m_sk;
    int m_hpol = 0, m_vpol = 0, m_bord = 0, m_ufl = 'hFF, m_fmt = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int msk(int fmt, int c);
        int bits = (fmt == 1) ? 4 : (fmt == 2) ? 5 : (fmt == 3) ? 6 : 8;
        int m = (255 << (8 - bits)) & 255;
        return c & ((m << 16) | (m << 8) | m);
    endfunction

    function automatic int pdat(int p);
        return (((p * 7) & 255) << 16) | (((p + 3) & 255) << 8) | ((255 - p) & 255);
    endfunction

    task automatic wr(int a, int dt);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = TG_AW'(a); wr_data = TG_DW'(dt);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one frame, position by position, with up to three writes at given positions
    task automatic run_frame(bit sync, int exp_uf, bit gaps,
                             int a0, int r0, int d0, int a1, int r1, int d1,
                             int a2, int r2, int d2);
        if (sync) begin
            int guard = 0;
            do begin @(negedge clk); #1; guard++; end
            while (!frame_o && guard < 1000);
            chk("R1 engine start after enable", int'(frame_o), 1);
        end
        for (int p = 0; p < m_fp; p++) begin
            int hc, vld, pd, ehs, evs, ede, epx;
            if (!(sync && p == 0)) begin @(negedge clk); #1; end
            vld = gaps ? int'((p % 7) != 3) : 1;
            pd = pdat(p);
            pix_vld_i = vld[0];
            pix_data_i = TG_PW'(pd);
            wr_en = 1'b0;
            if (p == a0) begin wr_en = 1'b1; wr_addr = TG_AW'(r0); wr_data = TG_DW'(d0); end
            if (p == a1) begin wr_en = 1'b1; wr_addr = TG_AW'(r1); wr_data = TG_DW'(d1); end
            if (p == a2) begin wr_en = 1'b1; wr_addr = TG_AW'(r2); wr_data = TG_DW'(d2); end
            #1;
            hc  = p % m_ht;
            ehs = int'(hc < m_hpw) ^ m_hpol;
            evs = int'(p >= m_sk && p < m_sk + m_vl) ^ m_vpol;
            ede = int'(hc >= m_hb && hc <= m_he && p >= m_vb && p <= m_ve);
            epx = msk(m_fmt, ede != 0 ? (vld != 0 ? pd : m_ufl) : m_bord);
            chk("R2/R6 hsync", int'(hsync_o), ehs);
            chk("R3/R6 vsync", int'(vsync_o), evs);
            chk("R4 de", int'(de_o), ede);
            chk("R4 ready", int'(pix_rdy_o), ede);
            chk("R5/R9 colour", int'(pix_o), epx);
            chk("R10 frame strobe", int'(frame_o), int'(p == 0));
        end
        chk("R10 underflow sticky", int'(uflow_o), exp_uf);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R7 actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_ht = HT; m_hpw = HSE - HSS; m_hb = HT - HSS; m_he = HT - (HSS - HD) - 1;
        m_fp = VT * HT; m_vl = (VSE - VSS) * HT; m_sk = 0;
        m_vb = (VT - VSS) * HT + m_sk; m_ve = m_fp - (VSS - VD) * HT + m_sk - 1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 hsync", int'(hsync_o), 0);
        chk("R1 vsync", int'(vsync_o), 0);
        chk("R1 de", int'(de_o), 0);
        chk("R1 ready", int'(pix_rdy_o), 0);
        chk("R1 frame", int'(frame_o), 0);
        chk("R1 uflow", int'(uflow_o), 0);

        wr(1, (m_hpw << 16) | m_ht);
        wr(2, (m_he << 16) | m_hb);
        wr(3, m_fp);
        wr(4, m_vl);
        wr(5, m_vb);
        wr(6, m_ve);
        #1;
        chk("R1 idle before enable", int'(de_o), 0);
        chk("R1 no frame before enable", int'(frame_o), 0);
        wr(0, 1);

        // F1: clean stream, default colours and depth
        run_frame(1, 0, 0, -1, 0, 0, -1, 0, 0, -1, 0, 0);
        // F2: gaps; R8 mid-frame writes of pulse width and polarity stay hidden
        run_frame(0, 1, 1, 50, 1, (3 << 16) | m_ht, 60, 8, 3, -1, 0, 0);
        m_hpw = 3; m_hpol = 1; m_vpol = 1;
        // F3: depth 5 and skew queued
        run_frame(0, 1, 1, 10, 11, 2, 20, 7, 5, -1, 0, 0);
        m_fmt = 2; m_sk = 5;
        // F4: clear sticky, queue depth 4 and new underflow colour
        run_frame(0, 0, 0, 0, 12, 0, 5, 11, 1, 8, 10, 'h3C5AF0);
        m_fmt = 1; m_ufl = 'h3C5AF0;
        // F5: R7 disable then re-enable inside frame, border queued
        run_frame(0, 1, 1, 2, 9, 'hA0B0C0, 100, 0, 0, 150, 0, 1);
        m_bord = 'hA0B0C0;
        // F6: R7 disable takes effect at frame end
        run_frame(0, 1, 1, 100, 0, 0, -1, 0, 0, -1, 0, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            chk("R7 idle de", int'(de_o), 0);
            chk("R7 idle frame", int'(frame_o), 0);
            chk("R7 idle hsync", int'(hsync_o), m_hpol);
            chk("R7 idle vsync", int'(vsync_o), m_vpol);
            chk("R7 idle border", int'(pix_o), msk(m_fmt, m_bord));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule